// File: doc/BRIEF.md
# Four-Slot Instruction TLB Replacement Tracker

This block keeps the least-recently-used order of a four-slot instruction TLB. The order is a six-bit pairwise-age field that sits in the top bits [31:26] of a shared 32-bit MMU control word. The lower 26 bits of that word belong to other logic. They pass through this block unchanged.

Each field bit records which slot of one pair was used more recently. A fixed mask/compare pattern picks one slot out of the field as the next victim. When a use of a slot is reported (a hit), the field is rewritten so that this slot becomes the newest. When a refill request arrives (an instruction lookup missed but the unified TLB held the entry), the block drives a write enable and the victim slot index to the TLB storage in that same cycle, and marks that slot newest. A software load of the field is also accepted, so any six-bit value can be placed in it. That includes values that match no pattern; such a value raises an error flag.

The TLB storage and the address compare are outside this block.

Top module: `itlb_lru_tracker`

## Requirements
- R1: While reset is asserted, and right after it, the field `ctl_o[31:26]` is 6'b000000 and `victim_o` is 3. `victim_err_o` is 0.
- R2: `ctl_o[25:0]` always equals `ctl_rest_i`. `ctl_o[31:26]` is the tracker field, where field bit k is control bit 26+k.
- R3: `victim_o` is the first slot, in the order 0, 1, 2, 3, whose pattern matches. Each pattern is written as (mask, value) over field bits [5:0]:
  - slot 0: (111000, 111000)
  - slot 1: (100110, 000110)
  - slot 2: (010101, 000001)
  - slot 3: (001011, 000000)
- R4: When no pattern matches, `victim_err_o` is 1. A refill request in that state gives `fill_we_o` = 0 and leaves the field unchanged.
- R5: A hit (`touch_vld_i` = 1) on slot s sets the field to (field AND A[s]) OR O[s] at the next clock edge. The masks are:
  - AND masks A: slot 0 000111, slot 1 111001, slot 2 111110, slot 3 111111.
  - OR masks O: slot 0 000000, slot 1 100000, slot 2 010100, slot 3 001011.
- R6: A refill request with no error and no software load raises `fill_we_o` in the same cycle, with `fill_slot_o` equal to `victim_o`. At the next edge the field takes the hit update for that slot.
- R7: A software load (`lru_wr_i` = 1) sets the field to `lru_wdata_i` at the next edge. It takes priority over a refill and over a hit in the same cycle, and it holds `fill_we_o` at 0.
- R8: When a refill and a hit come in the same cycle, the refill's slot updates the field and the hit is ignored.
- R9: From reset, four refills in a row fill slots 3, 2, 1, 0 and then return the field to 6'b000000.
- R10: With no load, refill or hit in a cycle, the field keeps its value.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| ctl_rest_i | input | 26 | Lower bits of the control word, passed through |
| lru_wr_i | input | 1 | Software load of the age field |
| lru_wdata_i | input | 6 | Value for the software load |
| touch_vld_i | input | 1 | A slot hit is reported |
| touch_idx_i | input | 2 | Slot that hit |
| refill_i | input | 1 | Instruction miss that the unified TLB can refill |
| ctl_o | output | 32 | Control word: age field above, passthrough below |
| victim_o | output | 2 | Slot that would be replaced now |
| victim_err_o | output | 1 | Field matches no replacement pattern |
| fill_we_o | output | 1 | Write the unified entry into the chosen slot |
| fill_slot_o | output | 2 | Slot index for that write |

## Verification
The bench runs back-to-back refills from reset. A tracker that updated the wrong pair bits would repeat a slot instead of cycling 3, 2, 1, 0, and would not return to zero.

A mixed sequence of hits is checked against hand-worked field values. One software load is made for each pattern, to catch a decoder with a swapped mask or compare value.

A load of a field that matches no pattern must raise the error flag and block the fill. A design that still wrote would corrupt a slot.

Two same-cycle collisions are also covered: a load together with a refill, and a refill together with a hit. Here a wrong priority shows up as the wrong field after the edge.

// File: rtl/itlb_lru_pkg.sv
`timescale 1ns/1ps
package itlb_lru_pkg;

   localparam int SLOTS    = 4;
   localparam int AGE_BITS = 6;

   typedef logic [AGE_BITS-1:0] age_t;

   // bits that must be examined to call slot s the oldest
   function automatic age_t pick_mask(input int s);
      case (s)
         0:       pick_mask = 6'b111000;
         1:       pick_mask = 6'b100110;
         2:       pick_mask = 6'b010101;
         default: pick_mask = 6'b001011;
      endcase
   endfunction

   // value those bits must hold for slot s to be the oldest
   function automatic age_t pick_value(input int s);
      case (s)
         0:       pick_value = 6'b111000;
         1:       pick_value = 6'b000110;
         2:       pick_value = 6'b000001;
         default: pick_value = 6'b000000;
      endcase
   endfunction

   // pair bits cleared when slot s becomes the newest
   function automatic age_t keep_mask(input int s);
      case (s)
         0:       keep_mask = 6'b000111;
         1:       keep_mask = 6'b111001;
         2:       keep_mask = 6'b111110;
         default: keep_mask = 6'b111111;
      endcase
   endfunction

   // pair bits set when slot s becomes the newest
   function automatic age_t set_mask(input int s);
      case (s)
         0:       set_mask = 6'b000000;
         1:       set_mask = 6'b100000;
         2:       set_mask = 6'b010100;
         default: set_mask = 6'b001011;
      endcase
   endfunction

endpackage

// File: rtl/itlb_lru_decode.sv
`timescale 1ns/1ps
module itlb_lru_decode
   import itlb_lru_pkg::*;
#(
   parameter int ENTRIES = 4,
   parameter int FLD_W   = 6,
   localparam int IDX_W  = $clog2(ENTRIES)
) (
   input  logic [FLD_W-1:0] age_i,
   output logic [IDX_W-1:0] oldest_o,
   output logic             none_o
);

   logic [ENTRIES-1:0] match;

   for (genvar e = 0; e < ENTRIES; e++) begin : g_match
      localparam age_t MSK = pick_mask(e);
      localparam age_t VAL = pick_value(e);
      assign match[e] = ((age_i & MSK) == VAL);
   end

   // lowest-numbered matching slot wins
   always_comb begin
      oldest_o = IDX_W'(ENTRIES - 1);
      for (int e = ENTRIES - 1; e >= 0; e--) begin
         if (match[e]) oldest_o = IDX_W'(e);
      end
   end

   assign none_o = ~|match;

endmodule

// File: rtl/itlb_lru_update.sv
`timescale 1ns/1ps
module itlb_lru_update
   import itlb_lru_pkg::*;
#(
   parameter int ENTRIES = 4,
   parameter int FLD_W   = 6,
   localparam int IDX_W  = $clog2(ENTRIES)
) (
   input  logic [FLD_W-1:0] age_i,
   input  logic [IDX_W-1:0] slot_i,
   output logic [FLD_W-1:0] age_o
);

   logic [FLD_W-1:0] keep_tab [ENTRIES];
   logic [FLD_W-1:0] set_tab  [ENTRIES];

   for (genvar e = 0; e < ENTRIES; e++) begin : g_tab
      assign keep_tab[e] = keep_mask(e);
      assign set_tab[e]  = set_mask(e);
   end

   // clear first, then set
   assign age_o = (age_i & keep_tab[slot_i]) | set_tab[slot_i];

endmodule

// File: rtl/itlb_lru_state.sv
`timescale 1ns/1ps
module itlb_lru_state #(
   parameter int FLD_W = 6
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             load_i,
   input  logic [FLD_W-1:0] load_val_i,
   input  logic             upd_i,
   input  logic [FLD_W-1:0] upd_val_i,
   output logic [FLD_W-1:0] age_o
);

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         age_o <= '0;
      end else if (load_i) begin
         age_o <= load_val_i;
      end else if (upd_i) begin
         age_o <= upd_val_i;
      end
   end

endmodule

// File: rtl/itlb_lru_tracker.sv
`timescale 1ns/1ps
module itlb_lru_tracker #(
   parameter int REG_W   = 32,
   parameter int LRU_LSB = 26,
   parameter int ENTRIES = 4,
   localparam int FLD_W  = REG_W - LRU_LSB,
   localparam int IDX_W  = $clog2(ENTRIES)
) (
   input  logic               clk,
   input  logic               rst_n,
   input  logic [LRU_LSB-1:0] ctl_rest_i,
   input  logic               lru_wr_i,
   input  logic [FLD_W-1:0]   lru_wdata_i,
   input  logic               touch_vld_i,
   input  logic [IDX_W-1:0]   touch_idx_i,
   input  logic               refill_i,
   output logic [REG_W-1:0]   ctl_o,
   output logic [IDX_W-1:0]   victim_o,
   output logic               victim_err_o,
   output logic               fill_we_o,
   output logic [IDX_W-1:0]   fill_slot_o
);

   if (ENTRIES != itlb_lru_pkg::SLOTS) begin : g_bad_entries
      $error("itlb_lru_tracker: pattern tables exist only for four slots");
   end
   if (FLD_W != ENTRIES * (ENTRIES - 1) / 2) begin : g_bad_field
      $error("itlb_lru_tracker: field width must equal the number of slot pairs");
   end

   logic [FLD_W-1:0] age_q;
   logic [FLD_W-1:0] age_nxt;
   logic [IDX_W-1:0] upd_slot;
   logic             refill_go;
   logic             upd_en;

   itlb_lru_decode #(.ENTRIES(ENTRIES), .FLD_W(FLD_W)) dec_i (
      .age_i    (age_q),
      .oldest_o (victim_o),
      .none_o   (victim_err_o)
   );

   assign refill_go = refill_i & ~victim_err_o & ~lru_wr_i;
   assign upd_slot  = refill_go ? victim_o : touch_idx_i;
   assign upd_en    = refill_go | touch_vld_i;

   itlb_lru_update #(.ENTRIES(ENTRIES), .FLD_W(FLD_W)) upd_i (
      .age_i  (age_q),
      .slot_i (upd_slot),
      .age_o  (age_nxt)
   );

   itlb_lru_state #(.FLD_W(FLD_W)) st_i (
      .clk        (clk),
      .rst_n      (rst_n),
      .load_i     (lru_wr_i),
      .load_val_i (lru_wdata_i),
      .upd_i      (upd_en),
      .upd_val_i  (age_nxt),
      .age_o      (age_q)
   );

   assign fill_we_o   = refill_go;
   assign fill_slot_o = victim_o;
   assign ctl_o       = {age_q, ctl_rest_i};

endmodule

// File: rtl/itlb_lru_chk.sv
`timescale 1ns/1ps
module itlb_lru_chk #(
   parameter int REG_W   = 32,
   parameter int LRU_LSB = 26,
   parameter int ENTRIES = 4,
   localparam int FLD_W  = REG_W - LRU_LSB,
   localparam int IDX_W  = $clog2(ENTRIES)
) (
   input logic               clk,
   input logic               rst_n,
   input logic [LRU_LSB-1:0] ctl_rest_i,
   input logic               lru_wr_i,
   input logic               touch_vld_i,
   input logic               refill_i,
   input logic [REG_W-1:0]   ctl_o,
   input logic [IDX_W-1:0]   victim_o,
   input logic               victim_err_o,
   input logic               fill_we_o,
   input logic [IDX_W-1:0]   fill_slot_o
);

   // R1
   reset_state_chk: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(rst_n) |-> (ctl_o[REG_W-1:LRU_LSB] == '0 && victim_o == IDX_W'(ENTRIES - 1)));

   // R2
   passthrough_chk: assert property (@(posedge clk) disable iff (!rst_n)
      ctl_o[LRU_LSB-1:0] == ctl_rest_i);

   // R4
   no_fill_on_err_chk: assert property (@(posedge clk) disable iff (!rst_n)
      fill_we_o |-> (!victim_err_o && refill_i));

   // R4
   err_only_after_load_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (!victim_err_o && !lru_wr_i) |=> !victim_err_o);

   // R6
   refilled_not_next_chk: assert property (@(posedge clk) disable iff (!rst_n)
      fill_we_o |=> (victim_o != $past(fill_slot_o)));

   // R7
   load_blocks_fill_chk: assert property (@(posedge clk) disable iff (!rst_n)
      lru_wr_i |-> !fill_we_o);

   // R10
   idle_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (!lru_wr_i && !refill_i && !touch_vld_i) |=> $stable(ctl_o[REG_W-1:LRU_LSB]));

endmodule

bind itlb_lru_tracker itlb_lru_chk #(
   .REG_W   (REG_W),
   .LRU_LSB (LRU_LSB),
   .ENTRIES (ENTRIES)
) chk_i (
   .clk          (clk),
   .rst_n        (rst_n),
   .ctl_rest_i   (ctl_rest_i),
   .lru_wr_i     (lru_wr_i),
   .touch_vld_i  (touch_vld_i),
   .refill_i     (refill_i),
   .ctl_o        (ctl_o),
   .victim_o     (victim_o),
   .victim_err_o (victim_err_o),
   .fill_we_o    (fill_we_o),
   .fill_slot_o  (fill_slot_o)
);

// File: tb/itlb_lru_tracker_tb_top.sv
`timescale 1ns/1ps
module itlb_lru_tracker_tb_top;

   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic [25:0] ctl_rest = 26'h0;
   logic        lru_wr = 1'b0;
   logic [5:0]  lru_wdata = 6'h0;
   logic        touch_vld = 1'b0;
   logic [1:0]  touch_idx = 2'd0;
   logic        refill = 1'b0;
   logic [31:0] ctl;
   logic [1:0]  victim;
   logic        victim_err;
   logic        fill_we;
   logic [1:0]  fill_slot;

   int n_checks = 0;
   int n_fail   = 0;
   int cycles   = 0;
   bit done     = 1'b0;

   always #10 clk = ~clk;

   itlb_lru_tracker dut_i (
      .clk          (clk),
      .rst_n        (rst_n),
      .ctl_rest_i   (ctl_rest),
      .lru_wr_i     (lru_wr),
      .lru_wdata_i  (lru_wdata),
      .touch_vld_i  (touch_vld),
      .touch_idx_i  (touch_idx),
      .refill_i     (refill),
      .ctl_o        (ctl),
      .victim_o     (victim),
      .victim_err_o (victim_err),
      .fill_we_o    (fill_we),
      .fill_slot_o  (fill_slot)
   );

   task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
      n_checks++;
      if (act !== exp) begin
         n_fail++;
         $display("FAIL %s: actual %0h expected %0h", req, act, exp);
      end
   endtask

   task automatic do_reset();
      @(negedge clk);
      rst_n = 1'b0;
      lru_wr = 1'b0; touch_vld = 1'b0; refill = 1'b0;
      @(negedge clk);
      rst_n = 1'b1;
   endtask

   task automatic sw_load(input logic [5:0] v);
      @(negedge clk);
      lru_wr = 1'b1; lru_wdata = v;
      @(negedge clk);
      lru_wr = 1'b0;
   endtask

   task automatic hit(input logic [1:0] s);
      @(negedge clk);
      touch_vld = 1'b1; touch_idx = s;
      @(negedge clk);
      touch_vld = 1'b0;
   endtask

   task automatic refill_expect(input string req, input logic [1:0] slot);
      @(negedge clk);
      refill = 1'b1;
      #1;
      check(req, {31'd0, fill_we}, 32'd1);
      check(req, {30'd0, fill_slot}, {30'd0, slot});
      @(negedge clk);
      refill = 1'b0;
   endtask

   task automatic t_reset();
      @(negedge clk);
      rst_n = 1'b0;
      #1;
      check("R1 field in reset", {26'd0, ctl[31:26]}, 32'd0);
      check("R1 victim in reset", {30'd0, victim}, 32'd3);
      check("R1 err in reset", {31'd0, victim_err}, 32'd0);
      @(negedge clk);
      rst_n = 1'b1;
      #1;
      check("R1 victim after reset", {30'd0, victim}, 32'd3);
   endtask

   task automatic t_passthrough();
      do_reset();
      @(negedge clk);
      ctl_rest = 26'h2a5c3e1;
      #1;
      check("R2 low bits", {6'd0, ctl[25:0]}, {6'd0, 26'h2a5c3e1});
      hit(2'd3);
      #1;
      check("R2 field part", {26'd0, ctl[31:26]}, 32'h0b);
      check("R2 low bits held", {6'd0, ctl[25:0]}, {6'd0, 26'h2a5c3e1});
   endtask

   task automatic t_round_robin();
      do_reset();
      refill_expect("R9 first refill", 2'd3);
      check("R6 field after refill of 3", {26'd0, ctl[31:26]}, 32'h0b);
      refill_expect("R9 second refill", 2'd2);
      refill_expect("R9 third refill", 2'd1);
      refill_expect("R9 fourth refill", 2'd0);
      check("R9 field back to zero", {26'd0, ctl[31:26]}, 32'h00);
      check("R9 victim wraps", {30'd0, victim}, 32'd3);
   endtask

   task automatic t_hits();
      do_reset();
      hit(2'd3);
      hit(2'd0);
      #1;
      check("R5 after hits 3,0", {26'd0, ctl[31:26]}, 32'h03);
      check("R3 victim after hits 3,0", {30'd0, victim}, 32'd2);
      hit(2'd1);
      #1;
      check("R5 after hit 1", {26'd0, ctl[31:26]}, 32'h21);
      hit(2'd2);
      #1;
      check("R5 after hit 2", {26'd0, ctl[31:26]}, 32'h34);
      check("R3 victim after hit 2", {30'd0, victim}, 32'd3);
      @(negedge clk);
      @(negedge clk);
      check("R10 idle hold", {26'd0, ctl[31:26]}, 32'h34);
   endtask

   task automatic t_decode();
      do_reset();
      sw_load(6'b111000);
      #1;
      check("R7 load value", {26'd0, ctl[31:26]}, 32'h38);
      check("R3 pattern slot 0", {30'd0, victim}, 32'd0);
      sw_load(6'b000110);
      #1;
      check("R3 pattern slot 1", {30'd0, victim}, 32'd1);
      sw_load(6'b000001);
      #1;
      check("R3 pattern slot 2", {30'd0, victim}, 32'd2);
      sw_load(6'b000000);
      #1;
      check("R3 pattern slot 3", {30'd0, victim}, 32'd3);
   endtask

   task automatic t_error();
      do_reset();
      sw_load(6'b101010);
      #1;
      check("R4 err raised", {31'd0, victim_err}, 32'd1);
      @(negedge clk);
      refill = 1'b1;
      #1;
      check("R4 fill blocked", {31'd0, fill_we}, 32'd0);
      @(negedge clk);
      refill = 1'b0;
      #1;
      check("R4 field unchanged", {26'd0, ctl[31:26]}, 32'h2a);
   endtask

   task automatic t_collisions();
      do_reset();
      @(negedge clk);
      lru_wr = 1'b1; lru_wdata = 6'b111000; refill = 1'b1;
      touch_vld = 1'b1; touch_idx = 2'd1;
      #1;
      check("R7 load suppresses fill", {31'd0, fill_we}, 32'd0);
      @(negedge clk);
      lru_wr = 1'b0; refill = 1'b0; touch_vld = 1'b0;
      #1;
      check("R7 load wins", {26'd0, ctl[31:26]}, 32'h38);
      do_reset();
      @(negedge clk);
      refill = 1'b1; touch_vld = 1'b1; touch_idx = 2'd0;
      #1;
      check("R8 fill slot with hit", {30'd0, fill_slot}, 32'd3);
      @(negedge clk);
      refill = 1'b0; touch_vld = 1'b0;
      #1;
      check("R8 refill wins over hit", {26'd0, ctl[31:26]}, 32'h0b);
   endtask

   always @(posedge clk) begin
      cycles++;
      if (cycles > 5000 && !done) begin
         n_checks++;
         n_fail++;
         $display("FAIL watchdog: actual %0d cycles expected under 5000", cycles);
         $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
         $finish;
      end
   end

   initial begin
      t_reset();
      t_passthrough();
      t_round_robin();
      t_hits();
      t_decode();
      t_error();
      t_collisions();
      done = 1'b1;
      $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
      $finish;
   end

endmodule